// File: doc/BRIEF.md
# Sequential Q8.8 Fixed-Point Divider

This block divides one unsigned Q8.8 fixed-point value by another and returns an unsigned Q8.8 quotient. The work is spread over many clock cycles. A one-cycle pulse on `start` begins an operation. `ready` drops on the next cycle and rises again once the quotient is final. While `ready` is high and `start` stays low, the quotient is held stable, even though the clock keeps running and the operand inputs may change.

Internally the divider pre-scales its operands so that the result keeps eight fractional bits. It widens the dividend into a double-width remainder register, shifted up by the fraction width, and places the divisor in the upper half of a double-width divisor register. It then runs the restoring algorithm. Each iteration makes a trial subtraction and tests the borrow. A failed trial is undone by adding the divisor back. The quotient shifts left to take in the new bit, and the divisor shifts right. A step counter addresses a table of control words that is computed at elaboration time. The first and last table entries are all zero, so the registers hold their contents whenever the counter sits on either entry.

The operand width `DW` and the fraction width `FRAC` are parameters (defaults 16 and 8). The divider runs `DW+1` iterations. One operation takes `2 + 3*(DW+1)` clock edges from the edge that samples `start` to the edge after which `ready` is high. That is 53 edges at the defaults.

Top module: `qdiv_q88`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters its idle state. After that edge `ready` is 1 and `quotient` is 0.
- R2: After a clock edge that samples `start` high, `ready` is 0. It stays 0 until exactly `2 + 3*(DW+1)` edges after that start edge (53 at the defaults), and from then on it is 1. The operands are sampled at the second edge after the start edge.
- R3: For a nonzero divisor, whenever floor(dividend·2^FRAC / divisor) is below 2^DW, `quotient` equals that value. For example, 3.0/2.0 gives 0x0180, and 1.0/3.0 gives 0x0055.
- R4: When floor(dividend·2^FRAC / divisor) is 2^DW or more, `quotient` is the low `DW` bits of the smaller of that value and 2^(DW+1)−1. For example, 0x0100/0x0001 gives 0x0000, 0x0180/0x0001 gives 0x8000, and 0x0200/0x0001 gives 0xFFFF.
- R5: A zero divisor yields an all-ones quotient (0xFFFF at the defaults).
- R6: While `ready` is 1 and `start` is 0, `quotient` and `ready` do not change, whatever the operand inputs do.
- R7: A `start` pulse while an operation is in progress abandons that operation. The new operation uses the operands present at its own load edge and completes with the full latency of R2, counted from the new start edge.
- R8: The trial test uses the borrow of a full-width subtraction, so divisors with the top bit set divide correctly. For example, 0xFFFF/0xFFFF gives 0x0100 and 0x0000/0x8000 gives 0. A failed trial restores the remainder to its value before the subtraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a new division (one-cycle pulse) |
| dividend | input | DW | Unsigned fixed-point dividend, FRAC fraction bits |
| divisor | input | DW | Unsigned fixed-point divisor, FRAC fraction bits |
| quotient | output | DW | Unsigned fixed-point quotient, FRAC fraction bits |
| ready | output | 1 | High when the quotient is final and held |

## Verification
The bench builds two copies of the divider. The first uses `DW=6` and `FRAC=3`. Its 64×64 operand space is small enough to sweep exhaustively, so every exact quotient, every truncated and saturated overflow, and every zero-divisor case at that width is compared against an arithmetic model. The second uses the default `DW=16` and `FRAC=8`. It takes directed operand pairs that reach the 17-bit saturation point, divisors with the top bit set, and the exact 53-edge latency. It also covers a restart in mid-operation and the result hold while the operands change.

// File: rtl/qdiv_pkg.sv
// Package: shared control-word type and table generator for the divider.
// Assumes: iteration count is positive; address 0 and every address past
// the last step map to the all-zero (hold) word.
package qdiv_pkg;

    typedef struct packed {
        logic ld;   // load operands, clear quotient
        logic sub;  // trial subtraction into remainder
        logic tst;  // restore on borrow, shift quotient bit in
        logic shd;  // shift divisor right by one
    } qdiv_cw_t;

    // Address of the final (hold) step for a given iteration count.
    function automatic int qdiv_last(input int iter);
        return 2 + 3 * iter;
    endfunction

    // Control word stored at a given table address.
    function automatic qdiv_cw_t qdiv_cw_at(input int addr, input int iter);
        qdiv_cw_t w;
        int       phase;
        w = '0;
        if (addr == 1) begin
            w.ld = 1'b1;
        end else if (addr >= 2 && addr < qdiv_last(iter)) begin
            phase = (addr - 2) % 3;
            case (phase)
                0:       w.sub = 1'b1;
                1:       w.tst = 1'b1;
                default: w.shd = 1'b1;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/qdiv_seq.sv
// Module: step counter plus control-word table.
// What it does: a start pulse clears the counter to 0; it then counts up
// to the last address and stays there. The table entry at the counter is
// the control word for the current cycle. ready is high on the last address.
// Assumes: ITER >= 1; reset parks the counter on the last (hold) address.
module qdiv_seq
    import qdiv_pkg::*;
#(
    parameter int ITER = 17
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    output qdiv_cw_t cw,
    output logic     ready
);
    localparam int LAST  = qdiv_last(ITER);
    localparam int CNT_W = $clog2(LAST + 1);
    localparam int DEPTH = 1 << CNT_W;

    logic [CNT_W-1:0] cnt;
    qdiv_cw_t         rom [DEPTH];

    // Table of control words, computed at elaboration.
    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        assign rom[i] = qdiv_cw_at(i, ITER);
    end

    // Step counter: restart on start, advance until the hold address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_W'(LAST);
        end else if (start) begin
            cnt <= '0;
        end else if (cnt != CNT_W'(LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Current control word and completion flag.
    always_comb begin
        cw    = rom[cnt];
        ready = (cnt == CNT_W'(LAST));
    end

endmodule

// File: rtl/qdiv_addsub.sv
// Module: W-bit adder/subtractor with borrow output.
// What it does: sum = a - b when sub is high, otherwise a + b; borrow is
// high when a subtraction goes below zero (no carry out of the top bit).
// Assumes: unsigned operands; borrow is meaningful only when sub is high.
module qdiv_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         borrow
);
    logic [W:0] ext;

    // One carry chain serves both operations via operand inversion.
    always_comb begin
        ext    = {1'b0, a} + {1'b0, (sub ? ~b : b)} + {{W{1'b0}}, sub};
        sum    = ext[W-1:0];
        borrow = sub & ~ext[W];
    end

endmodule

// File: rtl/qdiv_dp.sv
// Module: remainder, divisor and quotient registers of the restoring divider.
// What it does: on a load word it pre-scales the operands; on subtract,
// test and shift words it performs one phase of a restoring iteration.
// Assumes: FRAC < DW; exactly one control field is set per cycle.
module qdiv_dp
    import qdiv_pkg::*;
#(
    parameter int DW   = 16,
    parameter int FRAC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  qdiv_cw_t      cw,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic [DW-1:0] quotient
);
    localparam int RW = 2 * DW;

    logic [RW-1:0] rem;
    logic [RW-1:0] dvr;
    logic [DW-1:0] q;
    logic          neg;
    logic [RW-1:0] sum;
    logic          borrow;

    qdiv_addsub #(.W(RW)) u_as (
        .a      (rem),
        .b      (dvr),
        .sub    (cw.sub),
        .sum    (sum),
        .borrow (borrow)
    );

    // Register updates, one phase of the algorithm per control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
            dvr <= '0;
            q   <= '0;
            neg <= 1'b0;
        end else begin
            if (cw.ld) begin
                rem <= {{DW{1'b0}}, dividend} << FRAC;
                dvr <= {divisor, {DW{1'b0}}};
                q   <= '0;
                neg <= 1'b0;
            end
            if (cw.sub) begin
                rem <= sum;
                neg <= borrow;
            end
            if (cw.tst) begin
                if (neg) begin
                    rem <= sum;
                end
                q <= {q[DW-2:0], ~neg};
            end
            if (cw.shd) begin
                dvr <= dvr >> 1;
            end
        end
    end

    assign quotient = q;

    // R8
    restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cw.tst && neg) |=> (rem == $past(rem, 2)));

    // R8
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cw.tst && !neg) |=> (rem <= $past(rem, 2)));

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cw.ld |=> (q == '0 && dvr[DW-1:0] == '0));

endmodule

// File: rtl/qdiv_q88.sv
// Module: top of the sequential unsigned fixed-point divider.
// What it does: ties the step sequencer to the datapath; a start pulse
// begins a DW+1 iteration restoring division, ready marks a held result.
// Assumes: operands stable at the load step (second edge after start).
module qdiv_q88 #(
    parameter int DW   = 16,
    parameter int FRAC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic [DW-1:0] quotient,
    output logic          ready
);
    localparam int ITER = DW + 1;

    qdiv_pkg::qdiv_cw_t cw;

    qdiv_seq #(.ITER(ITER)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .cw    (cw),
        .ready (ready)
    );

    qdiv_dp #(.DW(DW), .FRAC(FRAC)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cw       (cw),
        .dividend (dividend),
        .divisor  (divisor),
        .quotient (quotient)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (ready && quotient == '0));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready);

    // R6
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> (ready && $stable(quotient)));

endmodule

// File: tb/sim_qdiv_q88.sv
module sim_qdiv_q88;
    localparam int CLK_P = 10;
    localparam int SDW = 6;
    localparam int SFR = 3;
    localparam int LDW = 16;
    localparam int LFR = 8;
    localparam int SLAST = 2 + 3 * (SDW + 1);
    localparam int LLAST = 2 + 3 * (LDW + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_start = 1'b0, l_start = 1'b0;
    logic [SDW-1:0] s_a = '0, s_b = '0, s_q;
    logic [LDW-1:0] l_a = '0, l_b = '0, l_q;
    logic s_rdy, l_rdy;
    int checks = 0;
    int errors = 0;

    always #(CLK_P / 2) clk = ~clk;

    qdiv_q88 #(.DW(SDW), .FRAC(SFR)) u0 (
        .clk(clk), .rst_n(rst_n), .start(s_start),
        .dividend(s_a), .divisor(s_b), .quotient(s_q), .ready(s_rdy));

    qdiv_q88 #(.DW(LDW), .FRAC(LFR)) u1 (
        .clk(clk), .rst_n(rst_n), .start(l_start),
        .dividend(l_a), .divisor(l_b), .quotient(l_q), .ready(l_rdy));

    function automatic longint model_full(longint a, longint b, int dw, int fr);
        longint lim = (longint'(1) << (dw + 1)) - 1;
        longint v;
        if (b == 0) v = lim;
        else begin
            v = (a << fr) / b;
            if (v > lim) v = lim;
        end
        return v;
    endfunction

    function automatic string tag_of(longint a, longint b, int dw, int fr);
        if (b == 0) return "R5";
        if (model_full(a, b, dw, fr) >= (longint'(1) << dw)) return "R4";
        if (b >= (longint'(1) << (dw - 1))) return "R8";
        return "R3";
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Exhaustive-sweep operation on the small instance.
    task automatic op_s(int a, int b);
        int k = 0;
        longint e;
        @(negedge clk);
        s_a = SDW'(a); s_b = SDW'(b); s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        while (!s_rdy && k < 200) begin
            @(negedge clk);
            k++;
        end
        e = model_full(a, b, SDW, SFR) & ((longint'(1) << SDW) - 1);
        check(tag_of(a, b, SDW, SFR), longint'(s_q), e);
    endtask

    // Directed operation on the default instance with latency check.
    task automatic op_l(int a, int b);
        int k = 0;
        longint e;
        @(negedge clk);
        l_a = LDW'(a); l_b = LDW'(b); l_start = 1'b1;
        @(negedge clk);
        l_start = 1'b0;
        check("R2 busy", longint'(l_rdy), 0);
        while (!l_rdy && k < 1000) begin
            @(negedge clk);
            k++;
        end
        check("R2 latency", k, LLAST);
        e = model_full(a, b, LDW, LFR) & ((longint'(1) << LDW) - 1);
        check(tag_of(a, b, LDW, LFR), longint'(l_q), e);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [LDW-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 ready", longint'(l_rdy), 1);
        check("R1 quotient", longint'(l_q), 0);
        check("R1 ready small", longint'(s_rdy), 1);
        check("R1 quotient small", longint'(s_q), 0);

        // R2 latency on the small instance
        begin
            int k = 0;
            @(negedge clk);
            s_a = 6'd8; s_b = 6'd8; s_start = 1'b1;
            @(negedge clk);
            s_start = 1'b0;
            while (!s_rdy && k < 200) begin
                @(negedge clk);
                k++;
            end
            check("R2 latency small", k, SLAST);
            check("R3 small 1.0/1.0", longint'(s_q), 8);
        end

        // R3 R4 R5 R8 exhaustive sweep at DW=6
        for (int a = 0; a < (1 << SDW); a++)
            for (int b = 0; b < (1 << SDW); b++)
                op_s(a, b);

        // Directed cases at the default width
        op_l(16'h0100, 16'h0100);   // R3 1.0/1.0
        op_l(16'h0300, 16'h0200);   // R3 0x0180
        op_l(16'h0100, 16'h0300);   // R3 0x0055
        op_l(16'h0001, 16'h0001);   // R3 0x0100
        op_l(16'h0100, 16'h0001);   // R4 truncated to 0
        op_l(16'h0180, 16'h0001);   // R4 0x8000
        op_l(16'h0200, 16'h0001);   // R4 saturated 0xFFFF
        op_l(16'h1234, 16'h0000);   // R5
        op_l(16'h0000, 16'h0000);   // R5
        op_l(16'hFFFF, 16'hFFFF);   // R8 0x0100
        op_l(16'h0000, 16'h8000);   // R8 0
        op_l(16'h7FFF, 16'h8001);   // R8
        op_l(16'hFFFF, 16'h0100);   // R3 0xFFFF exact

        // R6 hold while operands change
        op_l(16'h0500, 16'h0200);
        held = l_q;
        l_a = 16'h0001; l_b = 16'h0000;
        repeat (6) @(negedge clk);
        check("R6 quotient held", longint'(l_q), longint'(held));
        check("R6 ready held", longint'(l_rdy), 1);

        // R7 restart in mid-operation
        @(negedge clk);
        l_a = 16'h0001; l_b = 16'h0000; l_start = 1'b1;
        @(negedge clk);
        l_start = 1'b0;
        repeat (10) @(negedge clk);
        op_l(16'h0900, 16'h0300);   // R7 expects 0x0300
        check("R7 restart result", longint'(l_q), 16'h0300);

        summary();
    end
endmodule